// File: doc/BRIEF.md
# Tile Descriptor Cache with Invalidation

This block keeps the state a texture front end needs to describe eight tiles. Each tile has a descriptor register and a size register. A small table of load records is indexed by the upper bits of a texture memory word address. Each record remembers where a load came from in source memory, its pitch, and whether its odd lines were word swapped. Set-tile, set-size and load commands update this state. A lookup request for a tile index returns a resolved texture descriptor one cycle later: source address, pitch, effective width and height, and the swapped flag.

Resolving a descriptor takes several steps. First the tile's record is selected. If that record is not valid, the resolver uses record 0 plus a byte offset. A block load's placeholder pitch is replaced with one derived from the tile's line length. The reported dimensions are limited by the wrap mask and the clamp flag. Each resolved result is cached per tile behind a valid bit. A register write clears a tile's bit only when the write actually changes the stored contents. Any load clears every tile's bit, because a load can change what any tile resolves to.

Top module: `tile_desc_cache`

## Requirements
- R1: A lookup request (reqEn high at a clock edge) makes rspValid high for exactly the following cycle. rspValid is low in any cycle not preceded by a request.
- R2: A tile descriptor write with contents identical to the stored ones leaves that tile's cached result in place, so the next lookup hits. A write with different contents makes that tile's next lookup miss and leaves other tiles' cached results in place.
- R3: A tile size write follows the same rule as R2. An identical write keeps the cache entry. A differing write forces a miss, and the response then shows the new size.
- R4: Any load (block or tile) makes the next lookup of every tile miss (rspHit low).
- R5: A lookup that misses fills that tile's cache entry. A second lookup of the same tile with no change in between reports rspHit high and the same descriptor.
- R6: A load uses the record indexed by the loaded tile's texture word address shifted right by 4. A tile load stores its source address and pitch with the swapped flag cleared, and marks only that record valid.
- R7: A block load stores pitch all-ones and sets swapped exactly when its line increment is zero. It invalidates every record whose index is above its own and leaves the lower records valid.
- R8: When a tile's record is not valid, the address is record 0's address plus the tile's word address times 8, and pitch and swapped come from record 0.
- R9: A selected pitch of all ones is reported as line times 8, or line times 16 when the tile's texel size code is 3 (32-bit texels).
- R10: With a nonzero mask m, the dimension is 2^m. If that axis's clamp flag is set, the dimension is the smaller of 2^m and the tile size.
- R11: With a mask of zero, the dimension equals the tile size for that axis.
- R12: After reset no response is valid, and all tile registers, records and cache entries are cleared. A first lookup then misses and resolves against an all-zero record 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tileWrEn | input | 1 | Write a tile descriptor |
| tileWrIdx | input | 3 | Tile index for descriptor write |
| tileWrTmem | input | 9 | Texture memory word address |
| tileWrLine | input | 9 | Line length in 64-bit words |
| tileWrTexSize | input | 2 | Texel size code (3 = 32-bit) |
| tileWrMaskS | input | 4 | Wrap mask, S axis |
| tileWrMaskT | input | 4 | Wrap mask, T axis |
| tileWrClampS | input | 1 | Clamp flag, S axis |
| tileWrClampT | input | 1 | Clamp flag, T axis |
| sizeWrEn | input | 1 | Write a tile size |
| sizeWrIdx | input | 3 | Tile index for size write |
| sizeWrWidth | input | 16 | Tile width in texels |
| sizeWrHeight | input | 16 | Tile height in texels |
| loadEn | input | 1 | Load command |
| loadBlock | input | 1 | 1 = block load, 0 = tile load |
| loadTileIdx | input | 3 | Tile whose word address selects the record |
| loadAddr | input | 24 | Source address of the load |
| loadPitch | input | 16 | Source pitch (tile load) |
| loadIncr | input | 12 | Line increment (block load) |
| reqEn | input | 1 | Lookup request |
| reqIdx | input | 3 | Tile index to look up |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | Response came from the cache |
| rspAddr | output | 24 | Resolved source address |
| rspPitch | output | 16 | Resolved pitch |
| rspWidth | output | 16 | Effective width |
| rspHeight | output | 16 | Effective height |
| rspSwapped | output | 1 | Odd lines word swapped |

## Verification
The resolver is tried with four kinds of state. In the first, the tile's own record was filled by a tile load, so the stored pitch passes through. In the second, it was filled by a block load with zero and nonzero increments, which tells line-derived pitch apart from stored pitch and 16-bit from 32-bit scaling. In the third, the record is missing and record 0 was block loaded, which exposes the fallback offset. In the fourth, nothing is loaded after reset. Mask and clamp combinations are chosen so that the mask is smaller than the size on one axis and larger on the other, which separates 2^m, the clamped minimum and the plain size. The cache is probed by repeating lookups around identical writes, differing writes and loads, and watching rspHit together with the returned fields.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  parameter int ADDR_W    = 24;
  parameter int PITCH_W   = 16;
  parameter int DIM_W     = 16;
  parameter int TMEM_W    = 9;
  parameter int LINE_W    = 9;
  parameter int MASK_W    = 4;
  parameter int INCR_W    = 12;
  parameter int REC_SHIFT = 4;

  localparam int REC_IW = TMEM_W - REC_SHIFT;
  localparam int REC_N  = 1 << REC_IW;
  localparam logic [1:0] TEXEL_32 = 2'd3;

  typedef struct packed {
    logic [TMEM_W-1:0] tmem;
    logic [LINE_W-1:0] line;
    logic [1:0]        texSize;
    logic [MASK_W-1:0] maskS;
    logic [MASK_W-1:0] maskT;
    logic              clampS;
    logic              clampT;
  } tile_t;

  typedef struct packed {
    logic [DIM_W-1:0] width;
    logic [DIM_W-1:0] height;
  } extent_t;

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [PITCH_W-1:0] pitch;
    logic               swapped;
  } rec_t;

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [PITCH_W-1:0] pitch;
    logic [DIM_W-1:0]   width;
    logic [DIM_W-1:0]   height;
    logic               swapped;
  } desc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrTile;
    logic wrSize;
    logic wrRec;
    logic blockLoad;
    logic fill;
    logic useCache;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/tdc_resolve.sv
module tdc_resolve
  import tdc_pkg::*;
(
  input  tile_t   tile,
  input  extent_t ext,
  input  rec_t    rec,
  input  logic    recHit,
  input  rec_t    rec0,
  output desc_t   desc
);
  function automatic logic [DIM_W-1:0] limitDim(input logic [DIM_W-1:0] sz,
                                                input logic [MASK_W-1:0] m,
                                                input logic cl);
    logic [DIM_W-1:0] span;
    span = DIM_W'(1) << m;
    if (m == '0)            return sz;
    else if (cl && sz < span) return sz;
    else                    return span;
  endfunction

  logic [PITCH_W-1:0] basePitch;
  logic               baseSwap;
  logic [ADDR_W-1:0]  baseAddr;

  always_comb begin
    // R8: missing record falls back to record 0 plus word offset
    if (recHit) begin
      baseAddr  = rec.addr;
      basePitch = rec.pitch;
      baseSwap  = rec.swapped;
    end else begin
      baseAddr  = rec0.addr + ADDR_W'({tile.tmem, 3'b000});
      basePitch = rec0.pitch;
      baseSwap  = rec0.swapped;
    end

    desc.addr    = baseAddr;
    desc.swapped = baseSwap;
    // R9: placeholder pitch from block load becomes line-derived
    if (basePitch == '1)
      desc.pitch = (tile.texSize == TEXEL_32) ? PITCH_W'({tile.line, 4'b0000})
                                              : PITCH_W'({tile.line, 3'b000});
    else
      desc.pitch = basePitch;

    // R10 / R11
    desc.width  = limitDim(ext.width,  tile.maskS, tile.clampS);
    desc.height = limitDim(ext.height, tile.maskT, tile.clampT);
  end
endmodule

// File: rtl/tdc_ctrl.sv
module tdc_ctrl
  import tdc_pkg::*;
#(
  parameter int NUM_TILES = 8,
  localparam int IDX_W = $clog2(NUM_TILES)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqEn,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic             tileWrEn,
  input  logic [IDX_W-1:0] tileWrIdx,
  input  logic             tileDiff,
  input  logic             sizeWrEn,
  input  logic [IDX_W-1:0] sizeWrIdx,
  input  logic             sizeDiff,
  input  logic             loadEn,
  input  logic             loadBlock,
  output strobe_t          stb,
  output logic             rspValid,
  output logic             rspHit
);
  logic [NUM_TILES-1:0] cacheValid;
  logic [NUM_TILES-1:0] invMask;
  logic [NUM_TILES-1:0] fillMask;
  logic                 hit;

  assign hit = cacheValid[reqIdx];

  always_comb begin
    stb.wrTile    = tileWrEn;
    stb.wrSize    = sizeWrEn;
    stb.wrRec     = loadEn;
    stb.blockLoad = loadEn & loadBlock;
    stb.fill      = reqEn & ~hit;
    stb.useCache  = reqEn & hit;
    stb.capture   = reqEn;
  end

  // per-tile invalidate / fill decode
  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    assign invMask[t] = loadEn
                      | (tileWrEn && tileWrIdx == IDX_W'(t) && tileDiff)
                      | (sizeWrEn && sizeWrIdx == IDX_W'(t) && sizeDiff);
    assign fillMask[t] = stb.fill && reqIdx == IDX_W'(t);
  end

  // invalidation wins over a fill in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cacheValid <= '0;
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
    end else begin
      cacheValid <= (cacheValid | fillMask) & ~invMask;
      rspValid   <= reqEn;
      rspHit     <= reqEn & hit;
    end
  end

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqEn |=> rspValid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqEn |=> !rspValid);
  p_load_forces_miss_r4: assert property (@(posedge clk) disable iff (!rstN)
    loadEn ##1 reqEn |=> !rspHit);
  p_repeat_hits_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqEn && !loadEn && !tileWrEn && !sizeWrEn) ##1
    (reqEn && reqIdx == $past(reqIdx)) |=> rspHit);
endmodule

// File: rtl/tdc_dpath.sv
module tdc_dpath
  import tdc_pkg::*;
#(
  parameter int NUM_TILES = 8,
  localparam int IDX_W = $clog2(NUM_TILES)
)(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  tile_t              newTile,
  input  logic [IDX_W-1:0]   tileWrIdx,
  input  extent_t            newExt,
  input  logic [IDX_W-1:0]   sizeWrIdx,
  input  logic [IDX_W-1:0]   loadTileIdx,
  input  logic [ADDR_W-1:0]  loadAddr,
  input  logic [PITCH_W-1:0] loadPitch,
  input  logic [INCR_W-1:0]  loadIncr,
  input  logic [IDX_W-1:0]   reqIdx,
  output logic               tileDiff,
  output logic               sizeDiff,
  output desc_t              rspDesc
);
  tile_t             tiles    [NUM_TILES];
  extent_t           exts     [NUM_TILES];
  desc_t             cacheMem [NUM_TILES];
  rec_t              recs     [REC_N];
  logic [REC_N-1:0]  recValid;

  logic [REC_IW-1:0] loadRecIdx;
  logic [REC_IW-1:0] reqRecIdx;
  rec_t              newRec;
  tile_t             selTile;
  desc_t             resolved;

  assign tileDiff   = (tiles[tileWrIdx] != newTile);
  assign sizeDiff   = (exts[sizeWrIdx] != newExt);
  assign loadRecIdx = tiles[loadTileIdx].tmem[TMEM_W-1:REC_SHIFT];
  assign selTile    = tiles[reqIdx];
  assign reqRecIdx  = selTile.tmem[TMEM_W-1:REC_SHIFT];

  always_comb begin
    newRec.addr    = loadAddr;
    newRec.pitch   = stb.blockLoad ? '1 : loadPitch;
    newRec.swapped = stb.blockLoad && (loadIncr == '0);
  end

  tdc_resolve u_resolve (
    .tile   (selTile),
    .ext    (exts[reqIdx]),
    .rec    (recs[reqRecIdx]),
    .recHit (recValid[reqRecIdx]),
    .rec0   (recs[0]),
    .desc   (resolved)
  );

  // tile, size and cache storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_TILES; t++) begin
        tiles[t]    <= '0;
        exts[t]     <= '0;
        cacheMem[t] <= '0;
      end
    end else begin
      if (stb.wrTile) tiles[tileWrIdx] <= newTile;
      if (stb.wrSize) exts[sizeWrIdx]  <= newExt;
      if (stb.fill)   cacheMem[reqIdx] <= resolved;
    end
  end

  // load records
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recValid <= '0;
      for (int r = 0; r < REC_N; r++) recs[r] <= '0;
    end else if (stb.wrRec) begin
      for (int r = 0; r < REC_N; r++) begin
        if (REC_IW'(r) == loadRecIdx) begin
          recs[r]     <= newRec;
          recValid[r] <= 1'b1;
        end else if (stb.blockLoad && REC_IW'(r) > loadRecIdx) begin
          recValid[r] <= 1'b0;   // R7: clear records above
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rspDesc <= '0;
    else if (stb.capture) rspDesc <= stb.useCache ? cacheMem[reqIdx] : resolved;
  end

  // cached result must match a fresh resolve whenever it is used
  p_cache_coherent_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.useCache |-> cacheMem[reqIdx] == resolved);
  p_width_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && selTile.maskS != '0) |-> resolved.width <= (DIM_W'(1) << selTile.maskS));
  p_height_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && selTile.maskT == '0) |-> resolved.height == exts[reqIdx].height);
endmodule

// File: rtl/tile_desc_cache.sv
module tile_desc_cache
  import tdc_pkg::*;
#(
  parameter int NUM_TILES = 8,
  localparam int IDX_W = $clog2(NUM_TILES)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tileWrEn,
  input  logic [IDX_W-1:0]   tileWrIdx,
  input  logic [TMEM_W-1:0]  tileWrTmem,
  input  logic [LINE_W-1:0]  tileWrLine,
  input  logic [1:0]         tileWrTexSize,
  input  logic [MASK_W-1:0]  tileWrMaskS,
  input  logic [MASK_W-1:0]  tileWrMaskT,
  input  logic               tileWrClampS,
  input  logic               tileWrClampT,
  input  logic               sizeWrEn,
  input  logic [IDX_W-1:0]   sizeWrIdx,
  input  logic [DIM_W-1:0]   sizeWrWidth,
  input  logic [DIM_W-1:0]   sizeWrHeight,
  input  logic               loadEn,
  input  logic               loadBlock,
  input  logic [IDX_W-1:0]   loadTileIdx,
  input  logic [ADDR_W-1:0]  loadAddr,
  input  logic [PITCH_W-1:0] loadPitch,
  input  logic [INCR_W-1:0]  loadIncr,
  input  logic               reqEn,
  input  logic [IDX_W-1:0]   reqIdx,
  output logic               rspValid,
  output logic               rspHit,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic [PITCH_W-1:0] rspPitch,
  output logic [DIM_W-1:0]   rspWidth,
  output logic [DIM_W-1:0]   rspHeight,
  output logic               rspSwapped
);
  strobe_t stb;
  tile_t   newTile;
  extent_t newExt;
  desc_t   rspDesc;
  logic    tileDiff, sizeDiff;

  assign newTile = '{tmem: tileWrTmem, line: tileWrLine, texSize: tileWrTexSize,
                     maskS: tileWrMaskS, maskT: tileWrMaskT,
                     clampS: tileWrClampS, clampT: tileWrClampT};
  assign newExt  = '{width: sizeWrWidth, height: sizeWrHeight};

  tdc_ctrl #(.NUM_TILES(NUM_TILES)) u_ctrl (
    .clk, .rstN, .reqEn, .reqIdx, .tileWrEn, .tileWrIdx, .tileDiff,
    .sizeWrEn, .sizeWrIdx, .sizeDiff, .loadEn, .loadBlock,
    .stb, .rspValid, .rspHit
  );

  tdc_dpath #(.NUM_TILES(NUM_TILES)) u_dpath (
    .clk, .rstN, .stb, .newTile, .tileWrIdx, .newExt, .sizeWrIdx,
    .loadTileIdx, .loadAddr, .loadPitch, .loadIncr, .reqIdx,
    .tileDiff, .sizeDiff, .rspDesc
  );

  assign rspAddr    = rspDesc.addr;
  assign rspPitch   = rspDesc.pitch;
  assign rspWidth   = rspDesc.width;
  assign rspHeight  = rspDesc.height;
  assign rspSwapped = rspDesc.swapped;
endmodule

// File: tb/tile_desc_cache_tb_top.sv
`timescale 1ns/100ps
module tile_desc_cache_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tileWrEn = 0; logic [2:0] tileWrIdx = 0; logic [8:0] tileWrTmem = 0;
  logic [8:0] tileWrLine = 0; logic [1:0] tileWrTexSize = 0;
  logic [3:0] tileWrMaskS = 0, tileWrMaskT = 0; logic tileWrClampS = 0, tileWrClampT = 0;
  logic sizeWrEn = 0; logic [2:0] sizeWrIdx = 0; logic [15:0] sizeWrWidth = 0, sizeWrHeight = 0;
  logic loadEn = 0, loadBlock = 0; logic [2:0] loadTileIdx = 0; logic [23:0] loadAddr = 0;
  logic [15:0] loadPitch = 0; logic [11:0] loadIncr = 0;
  logic reqEn = 0; logic [2:0] reqIdx = 0;
  logic rspValid, rspHit, rspSwapped;
  logic [23:0] rspAddr; logic [15:0] rspPitch, rspWidth, rspHeight;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  tile_desc_cache dut_i (.*);

  typedef struct packed {
    logic [1:0] kind; logic pre0; logic [8:0] tmem; logic [8:0] line; logic [1:0] tsz;
    logic [3:0] mS; logic [3:0] mT; logic cS; logic cT; logic [15:0] w; logic [15:0] h;
    logic [23:0] la; logic [15:0] lp; logic [11:0] li;
    logic [23:0] ea; logic [15:0] ep; logic [15:0] ew; logic [15:0] eh; logic es;
  } vec_t;

  // kind: 0 none, 1 tile load, 2 block load ; pre0: block-load record 0 first
  localparam vec_t VECS [8] = '{
    '{2'd1,1'b0,9'h020,9'd8,2'd2,4'd0,4'd0,1'b0,1'b0,16'd32,16'd16,24'h002000,16'h0080,12'd0,24'h002000,16'h0080,16'd32,16'd16,1'b0},
    '{2'd2,1'b0,9'h030,9'd6,2'd2,4'd0,4'd0,1'b0,1'b0,16'd8,16'd8,24'h003000,16'h0000,12'd0,24'h003000,16'd48,16'd8,16'd8,1'b1},
    '{2'd2,1'b0,9'h030,9'd6,2'd3,4'd0,4'd0,1'b0,1'b0,16'd8,16'd8,24'h003000,16'h0000,12'd3,24'h003000,16'd96,16'd8,16'd8,1'b0},
    '{2'd1,1'b0,9'h020,9'd8,2'd2,4'd5,4'd3,1'b0,1'b1,16'd100,16'd10,24'h004000,16'h0100,12'd0,24'h004000,16'h0100,16'd32,16'd8,1'b0},
    '{2'd1,1'b0,9'h020,9'd8,2'd2,4'd6,4'd2,1'b1,1'b0,16'd20,16'd100,24'h004400,16'h0040,12'd0,24'h004400,16'h0040,16'd20,16'd4,1'b0},
    '{2'd0,1'b1,9'h040,9'd5,2'd1,4'd0,4'd0,1'b0,1'b0,16'd16,16'd16,24'h0,16'h0,12'd0,24'h001200,16'd40,16'd16,16'd16,1'b0},
    '{2'd0,1'b1,9'h015,9'd4,2'd3,4'd0,4'd0,1'b0,1'b0,16'd4,16'd4,24'h0,16'h0,12'd0,24'h0010A8,16'd64,16'd4,16'd4,1'b0},
    '{2'd0,1'b0,9'h010,9'd3,2'd2,4'd0,4'd0,1'b0,1'b0,16'd2,16'd2,24'h0,16'h0,12'd0,24'h000080,16'd0,16'd2,16'd2,1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setTile(input logic [2:0] idx, input logic [8:0] tm, input logic [8:0] ln,
                         input logic [1:0] ts, input logic [3:0] ms, input logic [3:0] mt,
                         input logic cs, input logic ct);
    @(negedge clk);
    tileWrEn = 1; tileWrIdx = idx; tileWrTmem = tm; tileWrLine = ln; tileWrTexSize = ts;
    tileWrMaskS = ms; tileWrMaskT = mt; tileWrClampS = cs; tileWrClampT = ct;
    @(negedge clk); tileWrEn = 0;
  endtask

  task automatic setSize(input logic [2:0] idx, input logic [15:0] w, input logic [15:0] h);
    @(negedge clk); sizeWrEn = 1; sizeWrIdx = idx; sizeWrWidth = w; sizeWrHeight = h;
    @(negedge clk); sizeWrEn = 0;
  endtask

  task automatic doLoad(input logic blk, input logic [2:0] idx, input logic [23:0] a,
                        input logic [15:0] p, input logic [11:0] inc);
    @(negedge clk); loadEn = 1; loadBlock = blk; loadTileIdx = idx;
    loadAddr = a; loadPitch = p; loadIncr = inc;
    @(negedge clk); loadEn = 0;
  endtask

  // outputs are valid at the negedge that ends this task
  task automatic lookup(input logic [2:0] idx);
    @(negedge clk); reqEn = 1; reqIdx = idx;
    @(negedge clk); reqEn = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    // ---- vector table: resolve paths R6 R7 R8 R9 R10 R11 R12
    foreach (VECS[i]) begin
      automatic vec_t v = VECS[i];
      doReset();
      if (v.pre0) begin
        setTile(3'd2, 9'h000, 9'd4, 2'd2, 4'd0, 4'd0, 1'b0, 1'b0);
        doLoad(1'b1, 3'd2, 24'h001000, 16'h0, 12'd5);
      end
      setTile(3'd1, v.tmem, v.line, v.tsz, v.mS, v.mT, v.cS, v.cT);
      setSize(3'd1, v.w, v.h);
      if (v.kind != 2'd0) doLoad(v.kind == 2'd2, 3'd1, v.la, v.lp, v.li);
      lookup(3'd1);
      chk(rspAddr == v.ea, $sformatf("vec%0d addr R6 R8", i), rspAddr, v.ea);
      chk(rspPitch == v.ep, $sformatf("vec%0d pitch R9", i), rspPitch, v.ep);
      chk(rspWidth == v.ew, $sformatf("vec%0d width R10 R11", i), rspWidth, v.ew);
      chk(rspHeight == v.eh, $sformatf("vec%0d height R10 R11", i), rspHeight, v.eh);
      chk(rspSwapped == v.es, $sformatf("vec%0d swapped R7", i), rspSwapped, v.es);
    end

    // ---- R12 / R1: reset state and response timing
    doReset();
    @(negedge clk);
    chk(rspValid == 1'b0, "R12 rspValid after reset", rspValid, 0);
    lookup(3'd5);
    chk(rspValid == 1'b1, "R1 rspValid one cycle after req", rspValid, 1);
    chk(rspHit == 1'b0, "R12 first lookup misses", rspHit, 0);
    @(negedge clk);
    chk(rspValid == 1'b0, "R1 rspValid drops", rspValid, 0);

    // ---- R5: miss then hit
    setTile(3'd3, 9'h020, 9'd8, 2'd2, 4'd0, 4'd0, 1'b0, 1'b0);
    setSize(3'd3, 16'd12, 16'd6);
    lookup(3'd3);
    chk(rspHit == 1'b0, "R5 first lookup miss", rspHit, 0);
    lookup(3'd3);
    chk(rspHit == 1'b1, "R5 second lookup hit", rspHit, 1);
    chk(rspWidth == 16'd12, "R5 cached width", rspWidth, 12);

    // ---- R2: tile rewrite rules
    setTile(3'd3, 9'h020, 9'd8, 2'd2, 4'd0, 4'd0, 1'b0, 1'b0);
    lookup(3'd3);
    chk(rspHit == 1'b1, "R2 identical tile write keeps entry", rspHit, 1);
    setTile(3'd4, 9'h010, 9'd2, 2'd2, 4'd0, 4'd0, 1'b0, 1'b0);
    setSize(3'd4, 16'd9, 16'd9);
    lookup(3'd4);
    setTile(3'd3, 9'h020, 9'd9, 2'd2, 4'd0, 4'd0, 1'b0, 1'b0);
    lookup(3'd3);
    chk(rspHit == 1'b0, "R2 differing tile write misses", rspHit, 0);
    lookup(3'd4);
    chk(rspHit == 1'b1, "R2 other tile unaffected", rspHit, 1);

    // ---- R3: size rewrite rules
    setSize(3'd4, 16'd9, 16'd9);
    lookup(3'd4);
    chk(rspHit == 1'b1, "R3 identical size write keeps entry", rspHit, 1);
    setSize(3'd4, 16'd24, 16'd9);
    lookup(3'd4);
    chk(rspHit == 1'b0, "R3 differing size write misses", rspHit, 0);
    chk(rspWidth == 16'd24, "R3 new width", rspWidth, 24);

    // ---- R4: any load clears all entries
    lookup(3'd3);
    doLoad(1'b0, 3'd3, 24'h000100, 16'h10, 12'd0);
    lookup(3'd4);
    chk(rspHit == 1'b0, "R4 load invalidates tile 4", rspHit, 0);
    lookup(3'd3);
    chk(rspHit == 1'b0, "R4 load invalidates tile 3", rspHit, 0);

    // ---- R6 / R7: record indexing and block-load clearing
    doReset();
    setTile(3'd0, 9'h010, 9'd2, 2'd2, 4'd0, 4'd0, 1'b0, 1'b0);
    setTile(3'd1, 9'h040, 9'd2, 2'd2, 4'd0, 4'd0, 1'b0, 1'b0);
    setTile(3'd2, 9'h020, 9'd10, 2'd2, 4'd0, 4'd0, 1'b0, 1'b0);
    doLoad(1'b0, 3'd0, 24'h007000, 16'h0020, 12'd0);
    doLoad(1'b0, 3'd1, 24'h005000, 16'h0030, 12'd0);
    lookup(3'd1);
    chk(rspAddr == 24'h005000, "R6 tile load record addr", rspAddr, 24'h005000);
    chk(rspPitch == 16'h0030, "R6 tile load pitch", rspPitch, 16'h0030);
    doLoad(1'b1, 3'd2, 24'h006000, 16'h0, 12'd1);
    lookup(3'd1);
    chk(rspAddr == 24'h000200, "R7 record above block load cleared", rspAddr, 24'h000200);
    lookup(3'd0);
    chk(rspAddr == 24'h007000, "R7 record below block load kept", rspAddr, 24'h007000);
    lookup(3'd2);
    chk(rspAddr == 24'h006000, "R7 block load addr", rspAddr, 24'h006000);
    chk(rspPitch == 16'd80, "R7 block load pitch from line", rspPitch, 80);
    chk(rspSwapped == 1'b0, "R7 nonzero increment not swapped", rspSwapped, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule